// File: doc/BRIEF.md
# Handshaked Synchronous Serial Master

This block moves one byte at a time over a three-wire synchronous link and generates the serial clock itself. A byte placed on the parallel input is latched by a start request, shifted out least significant bit first, while the byte arriving on the serial input is assembled and presented on the parallel output. The far end controls pacing through a busy line. After a start, the block waits until that line has been at its go level without a break for one and a half transfer-clock periods. Once the first clock edge has gone out, the busy line is ignored until all eight bits are done.

On completion the block raises a strobe for one transfer-clock period. One period later it drops its transfer-status flag. Polarity selects set the active level of the strobe and of the busy line. A block-mode select can hold back the strobe except on the final byte of a block. A held initialisation input parks every output at its idle level. The transfer-clock half period is given in system clocks and is never less than two.

The controller has six named states. IDLE waits for a start. GO_WAIT counts go-level samples of the busy line. SHIFT_LO is the low half of a bit cell and SHIFT_HI the high half. STROBE is the completion pulse period and TAIL is the period before the flag clears. The transitions are named as follows. ACCEPT goes from IDLE to GO_WAIT. HOLDOFF stays in GO_WAIT and restarts the count. LAUNCH goes from GO_WAIT to SHIFT_LO. RISE goes from SHIFT_LO to SHIFT_HI. FALL goes from SHIFT_HI to SHIFT_LO. FINISH goes from SHIFT_HI to STROBE. RELEASE goes from STROBE to TAIL. DONE goes from TAIL to IDLE. ABORT goes from any state to IDLE while initialisation is held.

Top module: `ser_hs_master`

## Requirements
- R1: While `init_i` is high, at every clock after the first sampled high: `flag_o` is 0, `sclk_o` is 1, `sdo_o` is 1, and `strb_o` is at its inactive level. A start request seen in that time is dropped. A transfer in progress is abandoned.
- R2: A start seen at a clock edge while idle and out of initialisation latches `tx_data_i`, `half_div_i`, `last_byte_i` and `last_only_i`. `flag_o` is 1 after that same edge.
- R3: The go level of `busy_i` is the inverse of `busy_pol_i` (with `busy_pol_i`=1, busy is active high). The first falling edge of `sclk_o` comes right after the 3·H-th consecutive clock edge at which `busy_i` is sampled at go. Here H is the effective half period. Any edge with busy active restarts the count.
- R4: `sclk_o` idles high. A transfer has exactly 8 bit cells. Each cell is H clocks low and then H clocks high, so falling edges are 2·H clocks apart.
- R5: `sdo_o` carries the byte least significant bit first. Each bit appears at the falling edge of its cell, and `sdo_o` is 1 outside a transfer. `sdi_i` is sampled at each rising edge of `sclk_o`, and the first bit sampled becomes bit 0. The assembled byte is on `rx_data_o` from the first strobe clock onwards.
- R6: Busy going active after the first falling edge does not stop or shorten the transfer.
- R7: The strobe becomes active 16·H clocks after the first falling edge and stays active for exactly 2·H clocks. `strb_pol_i`=1 makes the active level high, and 0 makes it low.
- R8: `flag_o` drops 2·H clocks after the strobe returns to inactive, which is 20·H clocks after the first falling edge.
- R9: With `last_only_i`=1 and `last_byte_i`=0 latched, no strobe pulse is given. Every other timing is unchanged.
- R10: A start request while `flag_o` is 1 is ignored. The byte in flight, its timing and its settings are not affected, and no second transfer follows.
- R11: The effective half period H is `half_div_i`, except that values 0 and 1 are treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Hold in initialisation, active high |
| start_i | input | 1 | Transfer start request |
| tx_data_i | input | 8 | Byte to send |
| rx_data_o | output | 8 | Last byte received |
| half_div_i | input | 8 | Transfer-clock half period in system clocks |
| strb_pol_i | input | 1 | 1: strobe active high, 0: active low |
| busy_pol_i | input | 1 | 1: busy active high, 0: active low |
| last_only_i | input | 1 | 1: strobe only on the final byte of a block |
| last_byte_i | input | 1 | This byte is the final one of its block |
| flag_o | output | 1 | Transfer-status flag |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Busy from the far end |
| strb_o | output | 1 | Completion strobe |

## Verification
Each result is due at a fixed distance from a known edge. The flag rises at the start edge itself. The first serial-clock fall comes 3·H edges after busy is first sampled at go, and everything after it follows at 2·H spacing. The strobe begins 16·H after that fall and lasts 2·H, and the flag drops 20·H after it. A monitor sampling at the falling system-clock edge stamps each event with the count of rising edges so far. The checks then compare those stamps with the expected offsets computed from the requirement formulas, using the chosen H, never by reading design internals.

// File: rtl/ser_hs_pkg.sv
package ser_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GO_WAIT,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_STROBE,
        ST_TAIL
    } ser_st_e;

    localparam int MIN_HALF = 2;

endpackage

// File: rtl/ser_hs_timer.sv
module ser_hs_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ser_hs_shifter.sv
module ser_hs_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              cap_i,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] tx_i,
    input  logic              sdi_i,
    output logic              bit_o,
    output logic [DATA_W-1:0] rx_o
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] rx_q;

    // transmit side: bit 0 is always the one on the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= tx_i;
        end else if (shift_i) begin
            tx_q <= {1'b0, tx_q[DATA_W-1:1]};
        end
    end

    // receive side: new bits enter at the top, so the first ends at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (cap_i) begin
            rx_sh_q <= {sdi_i, rx_sh_q[DATA_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (commit_i) begin
            rx_q <= rx_sh_q;
        end
    end

    assign bit_o = tx_q[0];
    assign rx_o  = rx_q;

    // R5: the parallel result moves only when a byte is committed
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(rx_q));

endmodule

// File: rtl/ser_hs_ctrl.sv
module ser_hs_ctrl
    import ser_hs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             start_i,
    input  logic             go_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             last_i,
    input  logic             last_only_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             cap_o,
    output logic             commit_o,
    output logic             run_o,
    output logic             sclk_o,
    output logic             flag_o,
    output logic             strb_act_o
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(MIN_HALF);

    ser_st_e           st_q, st_d;
    logic [BIT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  half_q;
    logic              strb_en_q;

    logic [DIV_W-1:0]  half_eff;
    logic [CNT_W-1:0]  half_w;
    logic [CNT_W-1:0]  lim_half;
    logic [CNT_W-1:0]  lim_period;
    logic [CNT_W-1:0]  lim_go;
    logic              hit_half;
    logic              hit_period;
    logic              hit_go;

    assign half_eff   = (half_i < HALF_MIN) ? HALF_MIN : half_i;
    assign half_w     = CNT_W'(half_q);
    assign lim_half   = half_w - CNT_W'(1);
    assign lim_period = (half_w << 1) - CNT_W'(1);
    assign lim_go     = half_w + (half_w << 1) - CNT_W'(1);
    assign hit_half   = (cnt_i == lim_half);
    assign hit_period = (cnt_i == lim_period);
    assign hit_go     = (cnt_i == lim_go);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d = ST_IDLE;                                   // ABORT
        end else begin
            unique case (st_q)
                ST_IDLE:     if (start_i) st_d = ST_GO_WAIT;  // ACCEPT
                ST_GO_WAIT:  if (go_i && hit_go) st_d = ST_SHIFT_LO; // LAUNCH, else HOLDOFF/count
                ST_SHIFT_LO: if (hit_half) st_d = ST_SHIFT_HI;       // RISE
                ST_SHIFT_HI: begin
                    if (hit_half) begin
                        st_d = (bit_q == LAST_BIT) ? ST_STROBE       // FINISH
                                                   : ST_SHIFT_LO;    // FALL
                    end
                end
                ST_STROBE:   if (hit_period) st_d = ST_TAIL;  // RELEASE
                ST_TAIL:     if (hit_period) st_d = ST_IDLE;  // DONE
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // state register and per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            bit_q     <= '0;
            half_q    <= HALF_MIN;
            strb_en_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_GO_WAIT) begin
                half_q    <= half_eff;
                strb_en_q <= !(last_only_i && !last_i);
            end
            if (st_q == ST_GO_WAIT && st_d == ST_SHIFT_LO) begin
                bit_q <= '0;
            end else if (st_q == ST_SHIFT_HI && st_d == ST_SHIFT_LO) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    // outputs and datapath controls
    always_comb begin
        run_o      = (st_q == ST_SHIFT_LO) || (st_q == ST_SHIFT_HI);
        sclk_o     = (st_q != ST_SHIFT_LO);
        flag_o     = (st_q != ST_IDLE);
        strb_act_o = (st_q == ST_STROBE) && strb_en_q;
        load_o     = (st_q == ST_IDLE)     && (st_d == ST_GO_WAIT);
        cap_o      = (st_q == ST_SHIFT_LO) && (st_d == ST_SHIFT_HI);
        shift_o    = (st_q == ST_SHIFT_HI) && (st_d == ST_SHIFT_LO);
        commit_o   = (st_q == ST_SHIFT_HI) && (st_d == ST_STROBE);
        cnt_clr_o  = (st_d != st_q) || (st_q == ST_IDLE) ||
                     ((st_q == ST_GO_WAIT) && !go_i);
    end

    // R1: initialisation parks the outputs at idle one clock later
    p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!flag_o && sclk_o && !strb_act_o));

    // R2: an accepted start raises the flag after the same edge
    p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_i && !init_i) |=> flag_o);

    // R4: a half cell never outlasts its limit
    p_half_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (cnt_i <= lim_half));

    // R6: once shifting, only the strobe period can follow
    p_no_cut_r6: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        run_o |=> (run_o || st_q == ST_STROBE));

    // R7: the strobe period is entered only after the last bit cell
    p_strobe_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STROBE && $past(st_q) != ST_STROBE) |-> (bit_q == LAST_BIT));

    // R10: a start during a transfer leaves its settings untouched
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        (flag_o && start_i) |=> ($stable(half_q) && $stable(strb_en_q)));

endmodule

// File: rtl/ser_hs_master.sv
module ser_hs_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              strb_pol_i,
    input  logic              busy_pol_i,
    input  logic              last_only_i,
    input  logic              last_byte_i,
    output logic              flag_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i,
    input  logic              busy_i,
    output logic              strb_o
);

    localparam int CNT_W = DIV_W + 2;

    logic             go;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             load;
    logic             shift;
    logic             cap;
    logic             commit;
    logic             run;
    logic             strb_act;
    logic             tx_bit;

    // go level is the inverse of the selected busy polarity
    assign go = busy_i ^ busy_pol_i;

    ser_hs_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    ser_hs_ctrl #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .start_i     (start_i),
        .go_i        (go),
        .half_i      (half_div_i),
        .last_i      (last_byte_i),
        .last_only_i (last_only_i),
        .cnt_i       (cnt),
        .cnt_clr_o   (cnt_clr),
        .load_o      (load),
        .shift_o     (shift),
        .cap_o       (cap),
        .commit_o    (commit),
        .run_o       (run),
        .sclk_o      (sclk_o),
        .flag_o      (flag_o),
        .strb_act_o  (strb_act)
    );

    ser_hs_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .shift_i  (shift),
        .cap_i    (cap),
        .commit_i (commit),
        .tx_i     (tx_data_i),
        .sdi_i    (sdi_i),
        .bit_o    (tx_bit),
        .rx_o     (rx_data_o)
    );

    assign sdo_o  = run ? tx_bit : 1'b1;
    assign strb_o = strb_pol_i ? strb_act : !strb_act;

    // R5: serial data rests high whenever no bit cell is running
    p_sdo_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> sdo_o);

    // R7: the strobe can only be active while the flag is raised
    p_strobe_in_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_o == strb_pol_i) |-> flag_o);

endmodule

// File: tb/ser_hs_master_tb_top.sv
module ser_hs_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic [7:0] rx_data_o;
    logic [7:0] half_div_i = 8'd2;
    logic       strb_pol_i = 1'b1;
    logic       busy_pol_i = 1'b1;
    logic       last_only_i = 1'b0;
    logic       last_byte_i = 1'b0;
    logic       flag_o;
    logic       sclk_o;
    logic       sdo_o;
    logic       sdi_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       strb_o;

    ser_hs_master dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .start_i     (start_i),
        .tx_data_i   (tx_data_i),
        .rx_data_o   (rx_data_o),
        .half_div_i  (half_div_i),
        .strb_pol_i  (strb_pol_i),
        .busy_pol_i  (busy_pol_i),
        .last_only_i (last_only_i),
        .last_byte_i (last_byte_i),
        .flag_o      (flag_o),
        .sclk_o      (sclk_o),
        .sdo_o       (sdo_o),
        .sdi_i       (sdi_i),
        .busy_i      (busy_i),
        .strb_o      (strb_o)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // monitor / slave model state
    int         n_fall, n_rise, n_strb;
    int         t_fall [16];
    int         t_rise [16];
    int         t_son, t_soff, t_foff;
    logic [7:0] got_tx, slave_q, rx_at_strb;
    logic       sclk_p = 1'b1, act_p = 1'b0, flag_p = 1'b0;
    int         s_cyc;

    function automatic logic strb_active();
        return strb_pol_i ? strb_o : !strb_o;
    endfunction

    always @(negedge clk) begin
        if (sclk_p && !sclk_o) begin
            if (n_fall < 16) t_fall[n_fall] = cyc;
            if (n_fall < 8) begin
                got_tx[n_fall] = sdo_o;
                sdi_i = slave_q[n_fall];
            end
            n_fall++;
        end
        if (!sclk_p && sclk_o) begin
            if (n_rise < 16) t_rise[n_rise] = cyc;
            n_rise++;
        end
        if (strb_active() && !act_p) begin
            t_son = cyc;
            n_strb++;
            rx_at_strb = rx_data_o;
        end
        if (!strb_active() && act_p) t_soff = cyc;
        if (flag_p && !flag_o) t_foff = cyc;
        sclk_p = sclk_o;
        act_p  = strb_active();
        flag_p = flag_o;
    end

    task automatic clr_mon();
        n_fall = 0; n_rise = 0; n_strb = 0;
        t_son = -1; t_soff = -1; t_foff = -1;
        got_tx = 8'h00; rx_at_strb = 8'h00;
        for (int i = 0; i < 16; i++) begin
            t_fall[i] = -1;
            t_rise[i] = -1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic set_busy(input bit active);
        busy_i = active ? busy_pol_i : !busy_pol_i;
    endtask

    task automatic cfg(input logic [7:0] half, input bit spol, input bit bpol,
                       input bit lonly, input bit lbyte);
        @(negedge clk);
        half_div_i  = half;
        strb_pol_i  = spol;
        busy_pol_i  = bpol;
        last_only_i = lonly;
        last_byte_i = lbyte;
        set_busy(1'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    // R2: start pulse, flag must be up after the sampling edge
    task automatic kick(input logic [7:0] tx, input logic [7:0] sl);
        @(negedge clk);
        clr_mon();
        slave_q   = sl;
        tx_data_i = tx;
        start_i   = 1'b1;
        s_cyc     = cyc + 1;
        @(negedge clk);
        start_i   = 1'b0;
        chk(flag_o == 1'b1, "R2", "flag after start", int'(flag_o), 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && flag_o; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_frame(input int f0, input int h, input logic [7:0] tx,
                               input logic [7:0] sl, input bit exp_strb);
        chk(t_fall[0] == f0, "R3", "first sclk fall cycle", t_fall[0], f0);
        chk(n_fall == 8, "R4", "sclk falling edges", n_fall, 8);
        chk(t_rise[0] - t_fall[0] == h, "R4", "low half length", t_rise[0] - t_fall[0], h);
        chk(t_fall[7] - t_fall[0] == 14*h, "R4", "fall spacing", t_fall[7] - t_fall[0], 14*h);
        chk(got_tx == tx, "R5", "bits seen on sdo", int'(got_tx), int'(tx));
        chk(rx_data_o == sl, "R5", "received byte", int'(rx_data_o), int'(sl));
        if (exp_strb) begin
            chk(t_son == f0 + 16*h, "R7", "strobe start", t_son, f0 + 16*h);
            chk(t_soff - t_son == 2*h, "R7", "strobe width", t_soff - t_son, 2*h);
            chk(rx_at_strb == sl, "R5", "byte at strobe", int'(rx_at_strb), int'(sl));
        end else begin
            chk(n_strb == 0, "R9", "suppressed strobe pulses", n_strb, 0);
        end
        chk(t_foff == f0 + 20*h, "R8", "flag clear cycle", t_foff, f0 + 20*h);
    endtask

    task automatic t_reset_state();
        chk(flag_o == 1'b0, "R1", "flag after reset", int'(flag_o), 0);
        chk(sclk_o == 1'b1, "R4", "sclk idle", int'(sclk_o), 1);
        chk(sdo_o == 1'b1, "R5", "sdo idle", int'(sdo_o), 1);
        chk(strb_o == 1'b0, "R7", "strobe idle (active high)", int'(strb_o), 0);
    endtask

    task automatic t_basic();
        cfg(8'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(8'hA5, 8'h3C);
        wait_idle();
        check_frame(s_cyc + 6, 2, 8'hA5, 8'h3C, 1'b1);
    endtask

    task automatic t_slow_lowpol();
        cfg(8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(strb_o == 1'b1, "R7", "active-low strobe idles high", int'(strb_o), 1);
        kick(8'h80, 8'h01);
        wait_idle();
        check_frame(s_cyc + 15, 5, 8'h80, 8'h01, 1'b1);
    endtask

    task automatic t_clamp();
        cfg(8'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(8'h5A, 8'hC3);
        wait_idle();
        chk(t_fall[0] == s_cyc + 6, "R11", "half 1 clamps to 2", t_fall[0], s_cyc + 6);
        check_frame(s_cyc + 6, 2, 8'h5A, 8'hC3, 1'b1);
        cfg(8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(8'hFF, 8'h00);
        wait_idle();
        chk(t_foff - t_fall[0] == 40, "R11", "half 0 clamps to 2", t_foff - t_fall[0], 40);
    endtask

    task automatic t_busy_gate();
        int c1, c2;
        cfg(8'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        set_busy(1'b1);
        kick(8'h96, 8'h69);
        repeat (4) @(negedge clk);
        c1 = cyc;
        set_busy(1'b0);
        repeat (5) @(negedge clk);
        set_busy(1'b1);
        repeat (3) @(negedge clk);
        chk(n_fall == 0, "R3", "no clock after short go window", n_fall, 0);
        c2 = cyc;
        set_busy(1'b0);
        wait_idle();
        chk(c2 > c1, "R3", "window ordering", c2, c1);
        check_frame(c2 + 9, 3, 8'h96, 8'h69, 1'b1);
    endtask

    task automatic t_busy_mid();
        cfg(8'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(8'h0F, 8'hF0);
        while (n_fall < 1) @(negedge clk);
        set_busy(1'b1);
        wait_idle();
        chk(n_fall == 8, "R6", "busy mid byte keeps clocking", n_fall, 8);
        check_frame(s_cyc + 6, 2, 8'h0F, 8'hF0, 1'b1);
        set_busy(1'b0);
    endtask

    task automatic t_start_ignored();
        int fz;
        cfg(8'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        kick(8'hC6, 8'h5D);
        while (n_fall < 3) @(negedge clk);
        tx_data_i  = 8'h11;
        half_div_i = 8'd7;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        wait_idle();
        check_frame(s_cyc + 6, 2, 8'hC6, 8'h5D, 1'b1);
        fz = n_fall;
        repeat (40) @(negedge clk);
        chk(flag_o == 1'b0, "R10", "no second transfer (flag)", int'(flag_o), 0);
        chk(n_fall == fz, "R10", "no second transfer (clocks)", n_fall, fz);
    endtask

    task automatic t_strobe_select();
        cfg(8'd2, 1'b1, 1'b1, 1'b1, 1'b0);
        kick(8'h33, 8'hCC);
        wait_idle();
        check_frame(s_cyc + 6, 2, 8'h33, 8'hCC, 1'b0);
        cfg(8'd2, 1'b1, 1'b1, 1'b1, 1'b1);
        kick(8'h44, 8'h22);
        wait_idle();
        chk(n_strb == 1, "R9", "final byte strobes", n_strb, 1);
        check_frame(s_cyc + 6, 2, 8'h44, 8'h22, 1'b1);
    endtask

    task automatic t_init();
        cfg(8'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        clr_mon();
        init_i = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(flag_o == 1'b0, "R1", "start under init dropped", int'(flag_o), 0);
        chk(n_fall == 0, "R1", "no clocks under init", n_fall, 0);
        chk(strb_o == 1'b1, "R1", "strobe inactive (active low)", int'(strb_o), 1);
        init_i = 1'b0;
        repeat (2) @(negedge clk);
        kick(8'hAA, 8'h55);
        while (n_fall < 3) @(negedge clk);
        init_i = 1'b1;
        @(negedge clk);
        chk(flag_o == 1'b0, "R1", "init aborts flag", int'(flag_o), 0);
        chk(sclk_o == 1'b1, "R1", "init parks sclk", int'(sclk_o), 1);
        chk(sdo_o == 1'b1, "R1", "init parks sdo", int'(sdo_o), 1);
        chk(strb_o == 1'b1, "R1", "init parks strobe", int'(strb_o), 1);
        init_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        clr_mon();
        slave_q = 8'h00;
        s_cyc   = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_slow_lowpol();
        t_clamp();
        t_busy_gate();
        t_busy_mid();
        t_start_ignored();
        t_strobe_select();
        t_init();
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
    end

endmodule